// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip scratchpad built from sixteen independent single-port banks of 256 words of 32 bits each, 16 KB in total. A caller presents a group of sixteen lanes at once. Each lane carries a valid bit, a 12-bit word address, a write enable and write data. Consecutive words go to consecutive banks. The block works out which lanes can share a cycle without two different rows being needed from one bank. It issues all of those lanes together and replays the rest on later cycles until the whole group is served.

Lanes that hit the same word in the same bank are merged into one bank access. A group in which every lane reads one word therefore costs a single cycle. The number of bank cycles a group takes is the largest count of distinct rows that any one bank must supply. When the group is finished, the read data of all sixteen lanes appears together with a one-cycle done pulse. A ready output is low while a group is in flight.

Top module: `sp_scratch`

## Requirements
- R1: After a synchronous reset, ready_o is 1, done_o is 0 and every lane of rdata_o is 0.
- R2: A lane's bank is address bits [3:0] and its row within that bank is bits [11:4]. Data written at a word address is read back from that same address, whichever lane pattern is used for the write and for the read.
- R3: A group whose valid lanes all hit different banks takes one bank cycle. Examples are a stride of 1 word, a stride of 3 words, or any permutation of banks with arbitrary rows.
- R4: A group that is accepted at a clock edge raises done_o after exactly N+1 further edges. N is the largest number of distinct rows needed from any one bank. A stride of 2 gives N=2, a stride of 8 gives N=8 and a stride of 16 gives N=16.
- R5: When all lanes read the same word, the group is a broadcast with N=1, and every lane returns that word.
- R6: Lanes that target the same word count once toward N. Eight lanes on one word plus eight lanes on another row of the same bank give N=2.
- R7: When several lanes of one group write the same word, the data of the highest-numbered lane is stored.
- R8: A lane that reads a word which another lane of the same group writes returns the contents from before the group.
- R9: Lanes whose valid bit is 0 make no access and return 0. A group with no valid lanes raises done_o one edge after it is accepted.
- R10: A group is accepted only at an edge where start_i and ready_o are both 1. ready_o falls after acceptance and stays low until done_o. start_i while ready_o is low has no effect on memory.
- R11: done_o is high for exactly one cycle, and in that cycle rdata_o holds the read data for every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Offer a lane group |
| lane_valid_i | input | 16 | Per-lane valid bits |
| lane_we_i | input | 16 | Per-lane write enables |
| lane_addr_i | input | 192 | Per-lane 12-bit word addresses, lane l at bits [12l+11:12l] |
| lane_wdata_i | input | 512 | Per-lane 32-bit write data, lane l at bits [32l+31:32l] |
| ready_o | output | 1 | Block can accept a group |
| done_o | output | 1 | One-cycle pulse, group complete |
| rdata_o | output | 512 | Per-lane 32-bit read data, lane l at bits [32l+31:32l] |

## Verification
Strides of 1 and 3 words and a scrambled bank permutation should each finish in one bank cycle. Strides of 2, 8 and 16 words should take 2, 8 and 16 cycles. Comparing the two sets shows whether the depth follows the number of distinct rows per bank or just the count of lanes sharing a bank. A broadcast group, and a group made of two clusters that each share one word, show whether same-word lanes are merged. Several lanes writing one word, a write mixed with reads of that word, partial and empty valid masks, and a start request held high while the block is busy test write priority, read-before-write ordering, idle lanes and the acceptance gate.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sp_state_e;
endpackage

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
  parameter int RW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [RW-1:0] row_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] q_o
);
  localparam int DEPTH = 1 << RW;
  logic [DW-1:0] mem [DEPTH];

  // read-first single port: q shows the old word on a write access
  always_ff @(posedge clk) begin
    if (en_i) begin
      q_o <= mem[row_i];
      if (we_i) mem[row_i] <= wd_i;
    end
  end
endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
  parameter int LANES   = 16,
  parameter int BW      = 4,
  parameter int RW      = 8,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         pend_i,
  input  logic [LANES*(BW+RW)-1:0] addr_i,
  input  logic [LANES-1:0]         we_i,
  input  logic [LANES*DW-1:0]      wdata_i,
  output logic [LANES-1:0]         serve_o,
  output logic                     en_o,
  output logic                     we_o,
  output logic [RW-1:0]            row_o,
  output logic [DW-1:0]            wd_o
);
  localparam int AW = BW + RW;
  localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

  logic [LANES-1:0] match;

  always_comb begin
    match   = '0;
    serve_o = '0;
    en_o    = 1'b0;
    we_o    = 1'b0;
    row_o   = '0;
    wd_o    = '0;
    for (int l = 0; l < LANES; l++)
      match[l] = pend_i[l] && (addr_i[l*AW +: BW] == MY_BANK);
    // lowest pending lane picks the row for this cycle
    for (int l = LANES-1; l >= 0; l--)
      if (match[l]) begin
        en_o  = 1'b1;
        row_o = addr_i[l*AW+BW +: RW];
      end
    // merge every pending lane on that row; ascending order lets the top lane win writes
    for (int l = 0; l < LANES; l++)
      if (match[l] && addr_i[l*AW+BW +: RW] == row_o) begin
        serve_o[l] = 1'b1;
        if (we_i[l]) begin
          we_o = 1'b1;
          wd_o = wdata_i[l*DW +: DW];
        end
      end
  end

  assert_pick_serves_R4: assert property (@(posedge clk) disable iff (rst)
    (|match) |-> (en_o && (serve_o != '0) && ((serve_o & ~match) == '0)));
endmodule

// File: rtl/sp_scratch.sv
module sp_scratch
  import sp_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int ROWS  = 256,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [15:0]          lane_valid_i,
  input  logic [15:0]          lane_we_i,
  input  logic [191:0]         lane_addr_i,
  input  logic [511:0]         lane_wdata_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic [511:0]         rdata_o
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = $clog2(ROWS);
  localparam int AW = BW + RW;

  sp_state_e             state;
  logic [LANES-1:0]      pend, cap, we_q, serve_all;
  logic [LANES*AW-1:0]   addr_q;
  logic [LANES*DW-1:0]   wdata_q, rdata_q;
  logic [LANES-1:0]      serve_b [BANKS];
  logic                  b_en [BANKS];
  logic                  b_we [BANKS];
  logic [RW-1:0]         b_row [BANKS];
  logic [DW-1:0]         b_wd [BANKS];
  logic [DW-1:0]         b_q [BANKS];
  int                    serve_sum;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_pick #(.LANES(LANES), .BW(BW), .RW(RW), .DW(DW), .BANK_ID(b)) u_pick (
      .clk(clk), .rst(rst), .pend_i(pend), .addr_i(addr_q), .we_i(we_q),
      .wdata_i(wdata_q), .serve_o(serve_b[b]), .en_o(b_en[b]), .we_o(b_we[b]),
      .row_o(b_row[b]), .wd_o(b_wd[b]));
    sp_bank_ram #(.RW(RW), .DW(DW)) u_ram (
      .clk(clk), .en_i(b_en[b]), .we_i(b_we[b]), .row_i(b_row[b]),
      .wd_i(b_wd[b]), .q_o(b_q[b]));
  end

  always_comb begin
    serve_all = '0;
    serve_sum = 0;
    for (int b = 0; b < BANKS; b++) begin
      serve_all = serve_all | serve_b[b];
      serve_sum = serve_sum + $countones(serve_b[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= '0;
      cap     <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      cap    <= serve_all;
      // lanes served last edge pick up the bank output now
      for (int l = 0; l < LANES; l++)
        if (cap[l]) rdata_q[l*DW +: DW] <= b_q[addr_q[l*AW +: BW]];
      case (state)
        ST_IDLE: if (start_i) begin
          state   <= ST_RUN;
          pend    <= lane_valid_i[LANES-1:0];
          we_q    <= lane_we_i[LANES-1:0];
          addr_q  <= lane_addr_i[LANES*AW-1:0];
          wdata_q <= lane_wdata_i[LANES*DW-1:0];
          rdata_q <= '0;
        end
        ST_RUN: begin
          pend <= pend & ~serve_all;
          if (pend == '0) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state == ST_IDLE);
  assign rdata_o = rdata_q;

  assert_one_bank_per_lane_R4: assert property (@(posedge clk) disable iff (rst)
    serve_sum == $countones(serve_all));
  assert_pend_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |=> ((pend & ~$past(pend)) == '0));
  assert_progress_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && pend != '0) |=> (pend != $past(pend)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_i) |=> !ready_o);
endmodule

// File: tb/sim_sp_scratch.sv
module sim_sp_scratch;
  localparam int LANES = 16;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [15:0] vmask, wmask;
  logic [191:0] addr_bus;
  logic [511:0] wdata_bus;
  logic ready, done;
  logic [511:0] rdata;

  always #2.5 clk = ~clk;

  sp_scratch u0 (
    .clk(clk), .rst(rst), .start_i(start), .lane_valid_i(vmask), .lane_we_i(wmask),
    .lane_addr_i(addr_bus), .lane_wdata_i(wdata_bus), .ready_o(ready),
    .done_o(done), .rdata_o(rdata));

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [512];
  logic [AW-1:0] la [LANES];
  logic [DW-1:0] ld [LANES];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) * 32'h0100_0193 + 32'h0000_0007;
  endfunction

  task automatic lanes_read(input int base, input int stride);
    vmask = '1;
    wmask = '0;
    for (int l = 0; l < LANES; l++) begin
      la[l] = AW'(base + l * stride);
      ld[l] = '0;
    end
  endtask

  task automatic do_group(input string req, input int expn, input bit inject);
    logic [DW-1:0] exp_rd [LANES];
    int lat;
    for (int l = 0; l < LANES; l++) begin
      addr_bus[l*AW +: AW] = la[l];
      wdata_bus[l*DW +: DW] = ld[l];
      exp_rd[l] = vmask[l] ? ref_mem[la[l]] : '0;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    check(ready == 1'b0, "R10", "ready while busy", 32'(ready), 32'd0);
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (inject && lat == 1) begin
        start = 1'b1;
        vmask = '1;
        wmask = '1;
        for (int l = 0; l < LANES; l++) begin
          addr_bus[l*AW +: AW] = AW'(l);
          wdata_bus[l*DW +: DW] = 32'hDEAD_0000;
        end
      end
      if (inject && lat == 3) start = 1'b0;
    end
    check(lat == expn + 1, req, "done latency", 32'(lat), 32'(expn + 1));
    for (int l = 0; l < LANES; l++)
      check(rdata[l*DW +: DW] == exp_rd[l], req, $sformatf("lane %0d data", l),
            rdata[l*DW +: DW], exp_rd[l]);
    if (!inject)
      for (int l = 0; l < LANES; l++)
        if (vmask[l] && wmask[l]) ref_mem[la[l]] = ld[l];
    @(negedge clk);
    check(done == 1'b0, "R11", "done width", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R1", "ready after reset", 32'(ready), 32'd1);
    check(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    check(rdata == '0, "R1", "rdata after reset", rdata[31:0], 32'd0);
  endtask

  task automatic t_fill();
    for (int g = 0; g < 16; g++) begin
      lanes_read(g * 16, 1);
      wmask = '1;
      for (int l = 0; l < LANES; l++) ld[l] = pat(g * 16 + l);
      do_group("R2", 1, 1'b0);
    end
  endtask

  task automatic t_stride(input int base, input int stride, input int expn, input string req);
    lanes_read(base, stride);
    do_group(req, expn, 1'b0);
  endtask

  task automatic t_perm();
    lanes_read(0, 0);
    for (int l = 0; l < LANES; l++) la[l] = AW'((l << 4) | ((l * 5 + 7) % 16));
    do_group("R3", 1, 1'b0);
  endtask

  task automatic t_broadcast();
    lanes_read(37, 0);
    do_group("R5", 1, 1'b0);
  endtask

  task automatic t_merge();
    lanes_read(0, 0);
    for (int l = 0; l < LANES; l++) la[l] = (l < 8) ? AW'(5) : AW'(21);
    do_group("R6", 2, 1'b0);
  endtask

  task automatic t_dupwrite();
    lanes_read(100, 0);
    wmask = '1;
    for (int l = 0; l < LANES; l++) ld[l] = 32'hA000_0000 + DW'(l);
    do_group("R7", 1, 1'b0);
    lanes_read(100, 0);
    do_group("R7", 1, 1'b0);
    check(rdata[31:0] == 32'hA000_000F, "R7", "top lane write kept", rdata[31:0], 32'hA000_000F);
  endtask

  task automatic t_readfirst();
    logic [DW-1:0] old;
    old = ref_mem[200];
    lanes_read(200, 0);
    wmask = 16'h0001;
    ld[0] = 32'h1234_5678;
    do_group("R8", 1, 1'b0);
    check(rdata[5*DW +: DW] == old, "R8", "reader sees old word", rdata[5*DW +: DW], old);
    lanes_read(200, 0);
    do_group("R8", 1, 1'b0);
  endtask

  task automatic t_partial();
    lanes_read(64, 1);
    vmask = 16'h00F0;
    do_group("R9", 1, 1'b0);
    lanes_read(64, 16);
    vmask = '0;
    do_group("R9", 0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    lanes_read(0, 16);
    do_group("R10", 16, 1'b1);
    t_stride(0, 1, 1, "R10");
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    vmask = '0;
    wmask = '0;
    addr_bus = '0;
    wdata_bus = '0;
    for (int i = 0; i < 512; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_stride(0, 1, 1, "R3");
    t_stride(0, 3, 1, "R3");
    t_perm();
    t_stride(0, 2, 2, "R4");
    t_stride(0, 8, 8, "R4");
    t_stride(0, 16, 16, "R4");
    t_broadcast();
    t_merge();
    t_dupwrite();
    t_readfirst();
    t_partial();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule